// File: doc/BRIEF.md
# Sync-Clock Duty Shutdown Monitor

This block watches a sampled synchronizing clock and decides, once per clock period, whether the gate drivers of a synchronous rectifier stage may run. It counts the ticks of each period and the ticks for which the sync clock was high. Each time a new rising edge arrives, it judges the period that has just ended. The result is a single registered enable for the gate sequencer.

There are two build variants. In the ratio variant, the enable drops when the duty falls below a low threshold. Once dropped, it comes back only when the duty reaches a higher threshold, so the hysteresis stops chatter near the limit. No divider is used: the block compares `high*100` against `pct*period`. In the low-duty variant, the ratio is ignored and each high pulse is judged only by its absolute width. A pulse that is too short withholds the enable for one period only. In both variants, a sync clock that stops forces the enable low.

Top module: `duty_guard`

## Requirements
- R1: After reset `drive_en` is 0. The first sync rising edge only starts a measurement. `drive_en` can become 1 no earlier than the second rising edge, and only if the period between the two edges was valid.
- R2: Ratio variant (`LOW_DUTY`=0), while enabled: a period of P ticks with H high ticks and `H*100 < OFF_PCT*P` clears `drive_en` at the rising edge that ends it.
- R3: Ratio variant, while enabled: a period with `H*100 == OFF_PCT*P` exactly (13 % at defaults) keeps `drive_en` at 1.
- R4: Ratio variant, while disabled: a period with `H*100 < ON_PCT*P` keeps `drive_en` at 0, even when its duty is at or above `OFF_PCT`.
- R5: Ratio variant, while disabled: a period with `H*100 >= ON_PCT*P` sets `drive_en` at the rising edge that ends it. An exact 18 % at defaults is enough.
- R6: `drive_en` changes only on the clock edge at which a sync rising edge is first sampled (sync_in 1, and 0 one cycle earlier), or on a stall (R7). It holds its value for the rest of the period.
- R7: If no rising edge arrives for `TIMEOUT` ticks, `drive_en` is forced to 0. The next rising edge then only restarts measurement, so enabling again takes one further full valid period.
- R8: Low-duty variant (`LOW_DUTY`=1): at each rising edge, `drive_en` becomes 1 exactly when the previous period's high time H satisfies `H >= MIN_HIGH`. An invalid pulse withholds the enable for that one period only.
- R9: Low-duty variant: the duty ratio has no effect. A 5 % duty with H >= `MIN_HIGH` enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one tick is one count |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Synchronizing clock, already sampled into the `clk` domain |
| drive_en | output | 1 | Registered enable for the gate sequencer |

## Verification
A wrong period or high-time count shows up as `drive_en` taking the wrong value right at the next sync rising edge. That is one `clk` cycle after the edge is sampled, so the error appears within one sync period. A corrupted hysteresis state shows up as either a missing enable after an 18 % period, or a missing drop after a 12 % period. A broken measurement-valid flag shows up as an early enable on the first edge after reset or after a stall. A broken stall counter shows up as an enable that survives a stopped clock, seen `TIMEOUT` ticks after the last edge.

// File: rtl/duty_guard.sv
module duty_guard #(
  parameter int CNT_W    = 16,
  parameter int OFF_PCT  = 13,
  parameter int ON_PCT   = 18,
  parameter int LOW_DUTY = 0,
  parameter int MIN_HIGH = 40,
  parameter int TIMEOUT  = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic drive_en
);
  localparam int PW = CNT_W + 7;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             sync_d, seen, verdict;
  logic [CNT_W-1:0] per_cnt, hi_cnt;

  wire rise    = sync_in & ~sync_d;
  wire stalled = per_cnt >= CNT_W'(TIMEOUT);

  generate
    if (LOW_DUTY != 0) begin : g_width
      assign verdict = hi_cnt >= CNT_W'(MIN_HIGH);
    end else begin : g_ratio
      logic [PW-1:0] hi_scaled, off_lim, on_lim;
      assign hi_scaled = {7'd0, hi_cnt} * PW'(100);
      assign off_lim   = {7'd0, per_cnt} * PW'(OFF_PCT);
      assign on_lim    = {7'd0, per_cnt} * PW'(ON_PCT);
      assign verdict   = drive_en ? (hi_scaled >= off_lim) : (hi_scaled >= on_lim);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_d   <= 1'b0;
      seen     <= 1'b0;
      drive_en <= 1'b0;
      per_cnt  <= '0;
      hi_cnt   <= '0;
    end else begin
      sync_d <= sync_in;
      if (rise) begin
        per_cnt  <= CNT_W'(1);
        hi_cnt   <= CNT_W'(1);
        seen     <= 1'b1;
        drive_en <= seen & verdict;
      end else begin
        if (!stalled) per_cnt <= per_cnt + 1'b1;
        if (sync_in && hi_cnt != CMAX) hi_cnt <= hi_cnt + 1'b1;
        if (stalled) begin
          drive_en <= 1'b0;
          seen     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/duty_guard_chk.sv
module duty_guard_chk #(
  parameter int OFF_PCT  = 13,
  parameter int ON_PCT   = 18,
  parameter int LOW_DUTY = 0,
  parameter int MIN_HIGH = 40,
  parameter int TIMEOUT  = 12000
) (
  input logic clk,
  input logic rst_n,
  input logic sync_in,
  input logic drive_en
);
  logic sp;
  int   rises, idle, per, hi, m_per, m_hi, run, last_run;
  wire  r = sync_in & ~sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= 1'b0; rises <= 0; idle <= 0; per <= 0; hi <= 0;
      m_per <= 0; m_hi <= 0; run <= 0; last_run <= 0;
    end else begin
      sp <= sync_in;
      if (r) begin
        if (rises < 2) rises <= rises + 1;
        idle <= 1; per <= 1; hi <= 1; m_per <= per; m_hi <= hi;
      end else begin
        if (idle < TIMEOUT + 2) idle <= idle + 1;
        if (per < 1000000) per <= per + 1;
        if (sync_in && hi < 1000000) hi <= hi + 1;
      end
      if (sync_in) begin
        if (run < 1000000) run <= run + 1;
      end else begin
        run <= 0;
        if (sp) last_run <= run;
      end
    end
  end

  a_r1_no_enable_on_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> rises >= 2);

  a_r6_rise_only_on_sync_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> $past(sync_in) && !$past(sync_in, 2));

  a_r7_stall_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    idle > TIMEOUT |-> !drive_en);

  generate
    if (LOW_DUTY != 0) begin : g_w
      a_r8_short_pulse_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> last_run >= MIN_HIGH);
    end else begin : g_r
      a_r5_enable_needs_on_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> m_hi * 100 >= ON_PCT * m_per);
      a_r2_drop_needs_low_duty: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive_en) && idle <= TIMEOUT) |-> m_hi * 100 < OFF_PCT * m_per);
    end
  endgenerate
endmodule

bind duty_guard duty_guard_chk #(
  .OFF_PCT(OFF_PCT), .ON_PCT(ON_PCT), .LOW_DUTY(LOW_DUTY),
  .MIN_HIGH(MIN_HIGH), .TIMEOUT(TIMEOUT)
) u_chk (.clk(clk), .rst_n(rst_n), .sync_in(sync_in), .drive_en(drive_en));

// File: tb/duty_guard_test.sv
module duty_guard_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_r = 1'b0;
  logic sync_w = 1'b0;
  logic en_r, en_w;
  int   checks = 0;
  int   errors = 0;

  always #2.5 clk = ~clk;

  duty_guard uut (.clk(clk), .rst_n(rst_n), .sync_in(sync_r), .drive_en(en_r));
  duty_guard #(.LOW_DUTY(1)) uut_w (.clk(clk), .rst_n(rst_n), .sync_in(sync_w), .drive_en(en_w));

  typedef struct { bit wide; bit exp; string req; } item_t;
  item_t sb[$];
  event  chk_ev;

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: drive_en=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input bit wide, input int h, input int p, input bit exp, input string req);
    item_t it;
    @(negedge clk);
    if (wide) sync_w = 1'b1; else sync_r = 1'b1;
    it.wide = wide; it.exp = exp; it.req = req;
    sb.push_back(it);
    -> chk_ev;
    repeat (h) @(negedge clk);
    if (wide) sync_w = 1'b0; else sync_r = 1'b0;
    repeat (p - h - 1) @(negedge clk);
    check(wide ? en_w : en_r, exp, "R6 held through period");
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(chk_ev);
      @(posedge clk);
      @(negedge clk);
      it = sb.pop_front();
      check(it.wide ? en_w : en_r, it.exp, it.req);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(en_r, 1'b0, "R1 reset ratio");
    check(en_w, 1'b0, "R1 reset width");
    pulse(0, 50, 100, 0, "R1 first edge only measures");
    pulse(0, 13, 100, 1, "R1 valid period enables");
    pulse(0, 12, 100, 1, "R3 exact off level keeps");
    pulse(0, 17, 100, 0, "R2 12pct drops");
    pulse(0, 18, 100, 0, "R4 17pct stays off");
    pulse(0, 50, 200, 1, "R5 exact 18pct enables");
    pulse(0, 25, 200, 1, "R2 25pct keeps");
    pulse(0, 60, 200, 0, "R2 12.5pct drops");
    pulse(0, 60, 200, 1, "R5 30pct enables");
    repeat (13000) @(negedge clk);
    check(en_r, 1'b0, "R7 stall forces off");
    pulse(0, 50, 100, 0, "R7 edge after stall only measures");
    pulse(0, 50, 100, 1, "R7 re-enable after full period");
    pulse(1, 39, 400, 0, "R8 first edge width");
    pulse(1, 40, 400, 0, "R8 39 ticks invalid");
    pulse(1, 39, 400, 1, "R8 40 ticks valid");
    pulse(1, 50, 1000, 0, "R8 one period only");
    pulse(1, 10, 100, 1, "R9 5pct wide pulse enables");
    pulse(1, 50, 400, 0, "R8 10 ticks invalid");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule